// File: doc/BRIEF.md
# Load Queue Ordering Guard

This block tracks in-flight loads of an out-of-order core in program order. Each dispatched load gets a slot and a tag. Later, when the load executes, its effective address is recorded against that tag. Every executing store is checked against the recorded loads. If a load that is younger than the store has already executed to the same 256-byte region, that load read stale data. The block flags it as the ordering violator so that the core can squash it and refetch.

Loads leave the queue in two ways. Retirement removes them from the oldest end, up to a youngest-committed sequence number. A squash removes them from the youngest end, above a given sequence number. Either operation finishes in one cycle, however many entries it removes.

The tag is the tail pointer, counted modulo twice the depth. A slot can be reused while an older tag for it is still held elsewhere in the core, and the two tags stay distinguishable. One slot is always held back, so a full queue and an empty queue never look the same.

Top module: `lq_order_guard`

## Requirements
- R1: After reset the queue is empty, `free_cnt` equals DEPTH-1 (7 by default), `viol_valid` is 0, `viol_count` is 0, and a store raises no `st_fault`.
- R2: When `alloc_valid` is high, `free_cnt` is nonzero and no squash is requested, `alloc_ok` is high in the same cycle. `alloc_tag` then takes successive values 0, 1, ..., 2*DEPTH-1 and wraps to 0. Each accepted insert lowers `free_cnt` by one from the next cycle.
- R3: When `free_cnt` is 0, `alloc_ok` is low and the insert has no effect: `free_cnt` stays 0.
- R4: A load takes part in the store search only after an `exec_valid` pulse carrying its tag has recorded its address. A younger load that has not executed never causes a fault.
- R5: An executing store raises `st_fault` in the same cycle when some executed load has a sequence number strictly greater than `st_seq`. The load's address and `st_addr` must also be equal after each is shifted right by 8 bits. Loads whose sequence number is equal to or smaller than `st_seq` are ignored.
- R6: When a store faults, the oldest matching load is latched from the next cycle. Its sequence number appears on `viol_seq`, its tag on `viol_tag`, `viol_valid` goes high, and `viol_count` increments by one.
- R7: While `viol_valid` is high, `st_fault` stays low and the latched violator does not change. A `viol_rd` pulse clears `viol_valid` from the next cycle.
- R8: A commit removes, in one cycle, every oldest entry whose sequence number is at most `commit_seq`. `free_cnt` rises by the number of entries removed, from the next cycle.
- R9: A squash removes, in one cycle, every entry whose sequence number is greater than `squash_seq`, and blocks any insert in that cycle. The next insert reuses the tag of the oldest removed entry, and the removed loads no longer match stores.
- R10: Addresses in different 256-byte regions never match. For example, 0x12FF matches 0x1200, but it does not match 0x1300.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Insert request for a dispatched load |
| alloc_seq | input | SEQ_W | Sequence number of the inserted load |
| alloc_ok | output | 1 | Insert accepted this cycle |
| alloc_tag | output | TW | Tag given to the inserted load |
| exec_valid | input | 1 | A load has computed its address |
| exec_tag | input | TW | Tag of the executing load |
| exec_addr | input | ADDR_W | Effective address of the executing load |
| st_valid | input | 1 | A store executes this cycle |
| st_seq | input | SEQ_W | Sequence number of the store |
| st_addr | input | ADDR_W | Effective address of the store |
| st_fault | output | 1 | The store found an ordering violation |
| commit_valid | input | 1 | Retire request |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Entries above this number are removed |
| free_cnt | output | TW | Free entries, with one reserved slot excluded |
| viol_valid | output | 1 | A violator is latched and unread |
| viol_seq | output | SEQ_W | Sequence number of the violator |
| viol_tag | output | TW | Tag of the violator |
| viol_rd | input | 1 | Read and clear the violator latch |
| viol_count | output | CNT_W | Running count of violations |

## Verification
The assertions assume the following about the inputs:
- Loads are inserted in increasing sequence order.
- Sequence numbers do not wrap.
- `exec_tag` names a live load.
- A commit and a squash in the same cycle never overlap, so no entry is both committed and squashed.

The directed stimulus follows all of these rules. Sequence numbers rise monotonically and stay far below the counter width. Every execute uses a tag that the bench tracked from the matching insert. Commit and squash are driven in separate cycles.

// File: rtl/lq_order_guard.sv
module lq_order_guard #(
  parameter int DEPTH      = 8,
  parameter int SEQ_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int REGION_LSB = 8,
  parameter int CNT_W      = 16,
  localparam int SW = $clog2(DEPTH),
  localparam int TW = SW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  output logic              alloc_ok,
  output logic [TW-1:0]     alloc_tag,
  input  logic              exec_valid,
  input  logic [TW-1:0]     exec_tag,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic              st_valid,
  input  logic [SEQ_W-1:0]  st_seq,
  input  logic [ADDR_W-1:0] st_addr,
  output logic              st_fault,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  output logic [TW-1:0]     free_cnt,
  output logic              viol_valid,
  output logic [SEQ_W-1:0]  viol_seq,
  output logic [TW-1:0]     viol_tag,
  input  logic              viol_rd,
  output logic [CNT_W-1:0]  viol_count
);

  logic [DEPTH-1:0]  vld, exd;
  logic [SEQ_W-1:0]  seq_q [DEPTH];
  logic [ADDR_W-1:0] adr_q [DEPTH];
  logic [TW-1:0]     head, tail, occ, exec_off;
  logic [TW-1:0]     ncom, nsq, hit_tag;
  logic [SW-1:0]     hit_slot;
  logic              hit, exec_ok;
  logic [DEPTH-1:0]  com_m, sq_m;

  assign occ       = tail - head;
  assign free_cnt  = TW'(DEPTH - 1) - occ;
  assign alloc_ok  = alloc_valid && !squash_valid && (free_cnt != '0);
  assign alloc_tag = tail;
  assign exec_off  = exec_tag - head;
  assign exec_ok   = exec_valid && (exec_off < occ);
  assign st_fault  = st_valid && !viol_valid && hit;

  always_comb begin
    ncom = '0;
    nsq  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      com_m[i] = commit_valid && vld[i] && (seq_q[i] <= commit_seq);
      sq_m[i]  = squash_valid && vld[i] && (seq_q[i] >  squash_seq);
      if (com_m[i]) ncom = ncom + TW'(1);
      if (sq_m[i])  nsq  = nsq  + TW'(1);
    end
  end

  always_comb begin
    logic [SW-1:0] s;
    hit      = 1'b0;
    hit_slot = '0;
    hit_tag  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      s = head[SW-1:0] + SW'(i);
      if (!hit && vld[s] && exd[s] && (seq_q[s] > st_seq) &&
          ((adr_q[s] >> REGION_LSB) == (st_addr >> REGION_LSB))) begin
        hit      = 1'b1;
        hit_slot = s;
        hit_tag  = head + TW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld        <= '0;
      exd        <= '0;
      head       <= '0;
      tail       <= '0;
      viol_valid <= 1'b0;
      viol_seq   <= '0;
      viol_tag   <= '0;
      viol_count <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        seq_q[i] <= '0;
        adr_q[i] <= '0;
      end
    end else begin
      head <= head + ncom;
      tail <= tail - nsq + TW'(alloc_ok);
      if (exec_ok) begin
        exd[exec_tag[SW-1:0]]   <= 1'b1;
        adr_q[exec_tag[SW-1:0]] <= exec_addr;
      end
      if (alloc_ok) begin
        vld[tail[SW-1:0]]   <= 1'b1;
        exd[tail[SW-1:0]]   <= 1'b0;
        seq_q[tail[SW-1:0]] <= alloc_seq;
      end
      for (int i = 0; i < DEPTH; i++) begin
        if (com_m[i] || sq_m[i]) begin
          vld[i] <= 1'b0;
          exd[i] <= 1'b0;
        end
      end
      if (viol_rd) viol_valid <= 1'b0;
      if (st_fault) begin
        viol_valid <= 1'b1;
        viol_seq   <= seq_q[hit_slot];
        viol_tag   <= hit_tag;
        viol_count <= viol_count + CNT_W'(1);
      end
    end
  end

  // R3
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= TW'(DEPTH - 1));

  // R2
  valid_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld) == int'(occ));

  // R6
  viol_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_fault |=> viol_valid && (viol_count == $past(viol_count) + CNT_W'(1)));

  // R7
  viol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_valid && !viol_rd) |=> viol_valid && $stable(viol_seq) && $stable(viol_tag));

  // R7
  one_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> !st_fault);

  // R9
  squash_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> occ <= $past(occ));

endmodule

// File: tb/lq_order_guard_test.sv
module lq_order_guard_test;
  logic        clk = 0, rst_n = 0;
  logic        alloc_valid = 0, exec_valid = 0, st_valid = 0;
  logic        commit_valid = 0, squash_valid = 0, viol_rd = 0;
  logic [15:0] alloc_seq = 0, st_seq = 0, commit_seq = 0, squash_seq = 0;
  logic [3:0]  exec_tag = 0;
  logic [31:0] exec_addr = 0, st_addr = 0;
  logic        alloc_ok, st_fault, viol_valid;
  logic [3:0]  alloc_tag, free_cnt, viol_tag;
  logic [15:0] viol_seq, viol_count;

  int checks = 0, fails = 0, nt = 0;
  int tag_b, tag_c, tag_d, tag_f;

  always #5 clk = ~clk;

  lq_order_guard uut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_ok(alloc_ok), .alloc_tag(alloc_tag),
    .exec_valid(exec_valid), .exec_tag(exec_tag), .exec_addr(exec_addr),
    .st_valid(st_valid), .st_seq(st_seq), .st_addr(st_addr), .st_fault(st_fault),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .free_cnt(free_cnt), .viol_valid(viol_valid), .viol_seq(viol_seq),
    .viol_tag(viol_tag), .viol_rd(viol_rd), .viol_count(viol_count));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_alloc(input int s, input string req);
    alloc_valid = 1; alloc_seq = 16'(s);
    #2;
    chk(req, "alloc_ok", 32'(alloc_ok), 1);
    chk(req, "alloc_tag", 32'(alloc_tag), 32'(nt % 16));
    step;
    alloc_valid = 0;
    nt++;
  endtask

  task automatic do_exec(input int tag, input logic [31:0] a);
    exec_valid = 1; exec_tag = 4'(tag); exec_addr = a;
    step;
    exec_valid = 0;
  endtask

  task automatic store_probe(input int s, input logic [31:0] a, input logic exp, input string req);
    st_valid = 1; st_seq = 16'(s); st_addr = a;
    #2;
    chk(req, "st_fault", 32'(st_fault), 32'(exp));
    step;
    st_valid = 0;
  endtask

  task automatic read_viol(input string req);
    viol_rd = 1;
    step;
    viol_rd = 0;
    chk(req, "viol_valid after read", 32'(viol_valid), 0);
  endtask

  task automatic do_commit(input int s);
    commit_valid = 1; commit_seq = 16'(s);
    step;
    commit_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1", "free_cnt", 32'(free_cnt), 7);
    chk("R1", "viol_valid", 32'(viol_valid), 0);
    chk("R1", "viol_count", 32'(viol_count), 0);
    store_probe(0, 32'h0, 0, "R1");
  endtask

  task automatic t_fill;
    for (int k = 0; k < 7; k++) begin
      do_alloc(10 + k, "R2");
      chk("R2", "free_cnt", 32'(free_cnt), 32'(6 - k));
    end
    alloc_valid = 1; alloc_seq = 17;
    #2;
    chk("R3", "alloc_ok when full", 32'(alloc_ok), 0);
    step;
    alloc_valid = 0;
    chk("R3", "free_cnt stays 0", 32'(free_cnt), 0);
    do_commit(100);
    chk("R8", "free_cnt after full commit", 32'(free_cnt), 7);
  endtask

  task automatic t_wrap_partial;
    for (int k = 0; k < 5; k++) do_alloc(20 + k, "R2");
    do_commit(22);
    chk("R8", "free_cnt after partial commit", 32'(free_cnt), 5);
    do_commit(100);
    chk("R8", "free_cnt after commit", 32'(free_cnt), 7);
  endtask

  task automatic t_violation;
    do_alloc(30, "R2");
    tag_b = nt % 16; do_alloc(31, "R2");
    tag_c = nt % 16; do_alloc(32, "R2");
    tag_d = nt % 16; do_alloc(33, "R2");
    do_exec(tag_b, 32'h1234);
    do_exec(tag_c, 32'h1280);
    do_exec(tag_d, 32'h12FF);
    store_probe(30, 32'h1200, 1, "R5");
    chk("R6", "viol_valid", 32'(viol_valid), 1);
    chk("R6", "viol_seq oldest", 32'(viol_seq), 31);
    chk("R6", "viol_tag", 32'(viol_tag), 32'(tag_b));
    chk("R6", "viol_count", 32'(viol_count), 1);
    store_probe(29, 32'h1200, 0, "R7");
    chk("R7", "viol_seq held", 32'(viol_seq), 31);
    chk("R7", "viol_count held", 32'(viol_count), 1);
    read_viol("R7");
    store_probe(33, 32'h1200, 0, "R5");
    store_probe(32, 32'h1200, 1, "R5");
    chk("R6", "viol_seq D", 32'(viol_seq), 33);
    chk("R6", "viol_count 2", 32'(viol_count), 2);
    read_viol("R7");
    store_probe(29, 32'h1300, 0, "R10");
    store_probe(29, 32'h11FF, 0, "R10");
  endtask

  task automatic t_unexecuted;
    tag_f = nt % 16; do_alloc(34, "R2");
    chk("R2", "tag wraps to 0", 32'(tag_f), 0);
    store_probe(33, 32'h1200, 0, "R4");
    do_exec(tag_f, 32'h12AB);
    store_probe(33, 32'h1200, 1, "R4");
    chk("R4", "viol_seq F", 32'(viol_seq), 34);
    chk("R4", "viol_tag F", 32'(viol_tag), 0);
    read_viol("R7");
  endtask

  task automatic t_squash;
    chk("R9", "free_cnt before squash", 32'(free_cnt), 2);
    squash_valid = 1; squash_seq = 31;
    alloc_valid = 1; alloc_seq = 39;
    #2;
    chk("R9", "alloc_ok during squash", 32'(alloc_ok), 0);
    step;
    squash_valid = 0; alloc_valid = 0;
    chk("R9", "free_cnt after squash", 32'(free_cnt), 5);
    nt = tag_c;
    do_alloc(40, "R9");
    store_probe(31, 32'h1200, 0, "R9");
    do_commit(30);
    chk("R8", "free_cnt after head commit", 32'(free_cnt), 5);
    store_probe(29, 32'h1234, 1, "R8");
    chk("R8", "surviving load seq", 32'(viol_seq), 31);
    read_viol("R7");
    do_commit(100);
    chk("R8", "free_cnt final", 32'(free_cnt), 7);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_fill;
    t_wrap_partial;
    t_violation;
    t_unexecuted;
    t_squash;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule